// File: doc/BRIEF.md
# Three-Level Pin Qualifier

This block turns a control pin that may be driven high, driven low or left open into a clean three-way code. It does not see the pin voltage. Two comparators outside the block compare the pin with an upper and a lower threshold, and the block receives their digital flags. A flag that is set means the pin is above the upper threshold, or below the lower threshold. When neither flag is set, the pin sits in the middle window and is taken to be floating. The flags are first passed through a synchronizer, because they may change at any time relative to the clock.

Moves between the two driven levels are reported at once. Moves into or out of the floating code each need their own stretch of uninterrupted evidence. Entry needs a long hold-off, so that a glitch or a slow edge that passes through the middle window is not read as a floating pin. Exit needs a shorter confirmation time. Both times are parameters counted in clock cycles. One instance with a short exit time serves a pulse-width input. A second instance, with an exit time of several thousand cycles, serves a mode-select pin, where a floating level means shutdown and leaving shutdown takes a long latency. The code MID also means "outputs off": it is the reset value, and the block reports it whenever the global enable is low.

Top module: `tri_level_qualifier`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `level_o` is MID. The encoding is LOW = 2'b00, HIGH = 2'b01, MID = 2'b10.
- R2: The synchronized flags decode to a raw level. `above_high`=1 gives HIGH, whatever `below_low` is. `above_high`=0 with `below_low`=1 gives LOW. Both at 0 gives MID.
- R3: When the output is HIGH or LOW and the raw level is the other driven level, the output takes the new level on the edge that first samples it. That edge is the SYNC_STAGES+1-th rising edge after the flags change.
- R4: From HIGH or LOW, the output becomes MID on the ENTER_CYC-th consecutive edge at which the raw level is MID. That edge is SYNC_STAGES+ENTER_CYC edges after the flags move into the window.
- R5: A stay in the middle window of fewer than ENTER_CYC cycles leaves a HIGH or LOW output unchanged. A return to a driven level restarts the hold-off count.
- R6: From MID, the output takes a driven level on the EXIT_CYC-th consecutive edge at which the raw level equals that level. That edge is SYNC_STAGES+EXIT_CYC edges after the flags change.
- R7: From MID, a driven level seen for fewer than EXIT_CYC cycles leaves the output at MID. A change to the other driven level, or back to the window, restarts the exit count.
- R8: While `en` is low, `level_o` is MID from the next edge on, and the flags are ignored. After `en` rises, a driven level must again hold for EXIT_CYC edges before it is reported.
- R9: `level_o` never carries the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable; when low, the output is forced to MID |
| above_high | input | 1 | Comparator flag: pin above the upper threshold (asynchronous) |
| below_low | input | 1 | Comparator flag: pin below the lower threshold (asynchronous) |
| level_o | output | 2 | Registered qualified level: 00 LOW, 01 HIGH, 10 MID |

## Verification
The bench sweeps every middle-window pulse width from one cycle up to one short of the hold-off, starting from both HIGH and LOW. A design that counted one cycle short, or that failed to restart its count, would drop to MID in the middle of one of these sweeps. It also sweeps every too-short driven pulse while the output is MID, and switches HIGH to LOW partway through an exit count. A design that kept a single count across both levels would then leave MID early. Exact-edge checks on entry, exit, direct swaps, flag priority, enable release, and the long exit time of the mode-pin instance catch any latency that is off by one register.

// File: rtl/tlq_pkg.sv
package tlq_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_MID  = 2'b10
  } level_e;
endpackage

// File: rtl/tlq_sync.sv
module tlq_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] d_i,
  output logic [1:0] q_o
);
  // one register per stage; reset value 00 decodes as the middle window
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [1:0] q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) q <= 2'b00;
        else     q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) q <= 2'b00;
        else     q <= g_stage[i-1].q;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/tlq_dwell.sv
module tlq_dwell
  import tlq_pkg::*;
#(
  parameter int LIMIT = 34,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  level_e        sample_i,
  output logic [CW-1:0] run_len_o
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);
  localparam logic [CW-1:0] ONE = CW'(1);

  level_e        tgt_q;
  logic [CW-1:0] cnt_q;

  // consecutive edges, this one included, with the same raw level; saturates
  always_comb begin
    if (sample_i != tgt_q)  run_len_o = ONE;
    else if (cnt_q == LIM)  run_len_o = LIM;
    else                    run_len_o = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tgt_q <= LVL_MID;
      cnt_q <= '0;
    end else begin
      tgt_q <= sample_i;
      cnt_q <= run_len_o;
    end
  end

  // R4
  run_len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    run_len_o != '0);
  // R5
  run_len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_len_o <= LIM);
endmodule

// File: rtl/tlq_classify.sv
module tlq_classify
  import tlq_pkg::*;
#(
  parameter int ENTER_CYC = 34,
  parameter int EXIT_CYC  = 9,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  level_e        raw_i,
  input  logic [CW-1:0] run_len_i,
  output level_e        state_o
);
  localparam logic [CW-1:0] ENTER_L = CW'(ENTER_CYC);
  localparam logic [CW-1:0] EXIT_L  = CW'(EXIT_CYC);

  level_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (raw_i == LVL_MID) begin
      if (state_q != LVL_MID && run_len_i >= ENTER_L) state_d = LVL_MID;
    end else if (state_q == LVL_MID) begin
      if (run_len_i >= EXIT_L) state_d = raw_i;
    end else begin
      state_d = raw_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) state_q <= LVL_MID;
    else            state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  reset_mid_chk: assert property (@(posedge clk) rst |=> state_q == LVL_MID);
  // R8
  disable_mid_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> state_q == LVL_MID);
  // R3
  direct_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state_q != LVL_MID && raw_i != LVL_MID && raw_i != state_q)
    |=> state_q == $past(raw_i));
  // R5
  mid_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state_q != LVL_MID && raw_i == LVL_MID && run_len_i < ENTER_L)
    |=> state_q != LVL_MID);
  // R7
  exit_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state_q == LVL_MID && raw_i != LVL_MID && run_len_i < EXIT_L)
    |=> state_q == LVL_MID);
  // R9
  legal_code_chk: assert property (@(posedge clk)
    state_q inside {LVL_LOW, LVL_HIGH, LVL_MID});
endmodule

// File: rtl/tri_level_qualifier.sv
module tri_level_qualifier
  import tlq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_CYC   = 34,
  parameter int EXIT_CYC    = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       above_high,
  input  logic       below_low,
  output logic [1:0] level_o
);
  localparam int LIMIT = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [1:0]    flags_s;
  level_e        raw;
  logic [CW-1:0] run_len;
  level_e        state;

  tlq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({above_high, below_low}),
    .q_o (flags_s)
  );

  // upper flag wins when both are set
  always_comb begin
    if (flags_s[1])      raw = LVL_HIGH;
    else if (flags_s[0]) raw = LVL_LOW;
    else                 raw = LVL_MID;
  end

  tlq_dwell #(.LIMIT(LIMIT)) u_dwell (
    .clk       (clk),
    .rst       (rst),
    .clr       (!en),
    .sample_i  (raw),
    .run_len_o (run_len)
  );

  tlq_classify #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC), .CW(CW)) u_classify (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .raw_i     (raw),
    .run_len_i (run_len),
    .state_o   (state)
  );

  assign level_o = state;

  // R2
  decode_prio_chk: assert property (@(posedge clk) disable iff (rst)
    flags_s[1] |-> raw == LVL_HIGH);
endmodule

// File: tb/tri_level_qualifier_tb.sv
`timescale 1ns/1ps
module tri_level_qualifier_tb;
  localparam int SYNC = 2;
  localparam int ENT  = 34;
  localparam int EXT  = 9;
  localparam int ENT_B = 40;
  localparam int EXT_B = 3750;
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, MD = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic ah_a = 1'b1, bl_a = 1'b0, ah_b = 1'b1, bl_b = 1'b0;
  logic [1:0] lvl_a, lvl_b;
  int checks = 0, failures = 0;
  bit seen_bad = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tri_level_qualifier #(.SYNC_STAGES(SYNC), .ENTER_CYC(ENT), .EXIT_CYC(EXT)) u_dut (
    .clk(clk), .rst(rst), .en(en), .above_high(ah_a), .below_low(bl_a), .level_o(lvl_a));

  tri_level_qualifier #(.SYNC_STAGES(SYNC), .ENTER_CYC(ENT_B), .EXIT_CYC(EXT_B)) u_dut_mode (
    .clk(clk), .rst(rst), .en(en), .above_high(ah_b), .below_low(bl_b), .level_o(lvl_b));

  always @(negedge clk) if (lvl_a == 2'b11 || lvl_b == 2'b11) seen_bad = 1'b1;

  task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_a(logic ah, logic bl);
    ah_a = ah; bl_a = bl;
  endtask

  // window pulse of width w from a driven level; output must hold that level
  task automatic glitch_sweep(string req, logic [1:0] hold, logic ah, logic bl);
    for (int w = 1; w < ENT; w++) begin
      logic [1:0] bad = hold;
      drive_a(1'b0, 1'b0);
      for (int k = 0; k < w; k++) begin tick(1); if (lvl_a !== hold) bad = lvl_a; end
      drive_a(ah, bl);
      for (int k = 0; k < SYNC + 4; k++) begin tick(1); if (lvl_a !== hold) bad = lvl_a; end
      chk(req, bad, hold);
    end
  endtask

  initial begin
    tick(3);
    chk("R1 reset A", lvl_a, MD);
    chk("R1 reset B", lvl_b, MD);
    rst = 1'b0;
    tick(SYNC + EXT - 1); chk("R6 exit not early", lvl_a, MD);
    tick(1);              chk("R6 exit edge", lvl_a, HI);

    glitch_sweep("R5 glitch from HIGH", HI, 1'b1, 1'b0);
    drive_a(1'b0, 1'b1); tick(SYNC + 1); chk("R3 HIGH to LOW", lvl_a, LO);
    glitch_sweep("R5 glitch from LOW", LO, 1'b0, 1'b1);

    drive_a(1'b0, 1'b0);
    tick(SYNC + ENT - 1); chk("R4 entry not early (LOW)", lvl_a, LO);
    tick(1);              chk("R4 entry edge (LOW)", lvl_a, MD);

    for (int w = 1; w < EXT; w++) begin
      logic [1:0] bad = MD;
      drive_a(1'b1, 1'b0);
      for (int k = 0; k < w; k++) begin tick(1); if (lvl_a !== MD) bad = lvl_a; end
      drive_a(1'b0, 1'b0);
      for (int k = 0; k < SYNC + EXT + 2; k++) begin tick(1); if (lvl_a !== MD) bad = lvl_a; end
      chk("R7 short driven pulse", bad, MD);
    end

    drive_a(1'b1, 1'b0); tick(5);
    drive_a(1'b0, 1'b1);
    tick(SYNC + EXT - 1); chk("R7 restart on level change", lvl_a, MD);
    tick(1);              chk("R7 restarted exit edge", lvl_a, LO);

    drive_a(1'b1, 1'b0);
    tick(SYNC); chk("R3 swap not early", lvl_a, LO);
    tick(1);    chk("R3 LOW to HIGH", lvl_a, HI);
    drive_a(1'b0, 1'b1);
    tick(SYNC); chk("R3 swap not early 2", lvl_a, HI);
    tick(1);    chk("R3 HIGH to LOW 2", lvl_a, LO);

    drive_a(1'b1, 1'b1);
    tick(SYNC + 1); chk("R2 both flags give HIGH", lvl_a, HI);

    drive_a(1'b0, 1'b0);
    tick(SYNC + ENT - 1); chk("R4 entry not early (HIGH)", lvl_a, HI);
    tick(1);              chk("R4 entry edge (HIGH)", lvl_a, MD);

    drive_a(1'b1, 1'b0); tick(SYNC + EXT + 2);
    chk("R6 back to HIGH", lvl_a, HI);
    en = 1'b0;
    tick(1);  chk("R8 disable forces MID", lvl_a, MD);
    tick(20); chk("R8 flags ignored while disabled", lvl_a, MD);
    en = 1'b1;
    tick(EXT - 1); chk("R8 no early report after enable", lvl_a, MD);
    tick(1);       chk("R8 report after exit count", lvl_a, HI);

    rst = 1'b1; tick(3); rst = 1'b0;
    tick(SYNC + EXT_B - 1); chk("R6 long exit not early", lvl_b, MD);
    tick(1);                chk("R6 long exit edge", lvl_b, HI);
    ah_b = 1'b0; bl_b = 1'b0;
    tick(SYNC + ENT_B - 1); chk("R4 mode pin entry not early", lvl_b, HI);
    tick(1);                chk("R4 mode pin entry edge", lvl_b, MD);

    chk("R9 no 2'b11 code", {1'b0, seen_bad}, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule